// File: doc/BRIEF.md
# Single-Cycle Instruction Sequencer with Unified Memory

This block owns the program counter and a word-organised memory that holds both code and data. On every cycle where the step input is high, it completes one instruction's worth of memory work. It presents the instruction word at the current PC, performs at most one load or store at the byte address supplied by an external ALU, and moves the PC to the following, branch or jump target. Decode and register writeback sit outside the block. The external decode logic reads `instr` and returns the control strobes in the same cycle.

Any illegal condition during a step raises a sticky `halted` flag instead of trapping. The illegal conditions are a bad fetch address, a fetched word of all zeros, a misaligned or out-of-range data access, and a step that asks for a read and a write together. While halted, the PC is frozen and stores are blocked until reset. A preload port writes words straight into memory so that a program can be placed there before stepping begins.

The address space is 2^ADDR_BITS bytes. A full 64 KB build uses ADDR_BITS = 16 and RESET_PC = 0x4000. The defaults are a small 8 KB configuration with the program starting at 0x1000.

Top module: `insn_seq_unit`

## Requirements
- R1: While rstN is low, and after it is released, the PC equals RESET_PC and halted is 0. instr then shows the memory word at RESET_PC.
- R2: Memory holds 2^(ADDR_BITS-2) words of 32 bits. The word for a byte address is found at index address[ADDR_BITS-1:2]. A preload with preloadEn high writes preloadData at word index preloadIdx on the clock edge.
- R3: A step with no branch or jump moves the PC to PC+4. A cycle with stepEn low changes neither the PC nor halted.
- R4: A step with jump=1 sets the PC to {(PC+4)[31:28], jumpField, 2'b00}. Jump takes priority over branch.
- R5: A step with branch=1 and zeroFlag=1 sets the PC to PC+4+(extOffset<<2), with extOffset treated as two's complement. If either input is 0, the PC moves to PC+4.
- R6: A step taken while the PC is not a multiple of 4, or while the PC is at or beyond 2^ADDR_BITS, sets halted.
- R7: A step whose fetched instruction word is 0x00000000 sets halted.
- R8: loadData always shows the word at aluResult. A step with memRead=1 sets halted if aluResult is not a multiple of 4 or is at or beyond 2^ADDR_BITS.
- R9: A step with memWrite=1 at a valid aligned aluResult writes storeData to that word. If the address is misaligned or out of range, the step sets halted and writes nothing.
- R10: A step with memRead=1 and memWrite=1 together sets halted and writes nothing.
- R11: When memRead and memWrite are both 0, aluResult is ignored. A misaligned value does not halt, and the PC advances normally.
- R12: Once halted is set, it stays set until reset. While halted, the PC does not move and steps write no memory. Reset clears halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Execute one instruction this cycle |
| memRead | input | 1 | Current instruction loads from memory |
| memWrite | input | 1 | Current instruction stores to memory |
| branch | input | 1 | Current instruction is a conditional branch |
| jump | input | 1 | Current instruction is an absolute jump |
| zeroFlag | input | 1 | ALU zero result, which qualifies a branch |
| aluResult | input | 32 | Byte address for a load or store |
| storeData | input | 32 | Data to store |
| extOffset | input | 32 | Sign-extended branch offset, in words |
| jumpField | input | 26 | Jump target field, in words |
| preloadEn | input | 1 | Write preloadData into memory |
| preloadIdx | input | ADDR_BITS-2 | Word index for the preload |
| preloadData | input | 32 | Preload word |
| instr | output | 32 | Instruction word at the current PC |
| loadData | output | 32 | Memory word at aluResult |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench fills the whole memory with distinct nonzero words and reads every word back at its byte address. An indexing slip would show up as a wrong word or an aliased location. Branch offsets are tried in both signs, and with the zero flag low as well as high. A design that ignored the zero flag, or failed to sign-extend the offset, would land the PC on the wrong word. Each halt cause is provoked on its own: a misaligned load, a misaligned store, an out-of-range access, both strobes at once, a jump past the end of memory, and a zero word. After each one, the bench checks that the halt appears on the right step and that the target word was left unchanged. It also checks that the PC stays put while halted, so a design that halted one step late or still wrote memory would be caught. A misaligned address with no access requested must not halt, which catches range checking that is applied unconditionally.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 32;
  localparam int JUMP_W = 26;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic doWrite;
    logic setHalt;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pcOk;
    logic instrZero;
    logic dataOk;
  } seqFlags_t;
endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int ADDR_BITS = 13,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strb,
  input  logic                  haltedIn,
  input  logic                  memRead,
  input  logic                  memWrite,
  input  logic                  branch,
  input  logic                  jump,
  input  logic                  zeroFlag,
  input  logic [WORD_W-1:0]     aluResult,
  input  logic [WORD_W-1:0]     storeData,
  input  logic [WORD_W-1:0]     extOffset,
  input  logic [JUMP_W-1:0]     jumpField,
  input  logic                  preloadEn,
  input  logic [ADDR_BITS-3:0]  preloadIdx,
  input  logic [WORD_W-1:0]     preloadData,
  output logic [WORD_W-1:0]     instr,
  output logic [WORD_W-1:0]     loadData,
  output seqFlags_t             flags
);
  localparam int WIDX  = ADDR_BITS - 2;
  localparam int DEPTH = 1 << WIDX;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] pcQ, pcPlus4, branchTgt, jumpTgt, nextPc;
  logic [WIDX-1:0]   fetchIdx, dataIdx;
  logic              pcHiZero, dataHiZero;

  assign fetchIdx = pcQ[ADDR_BITS-1:2];
  assign dataIdx  = aluResult[ADDR_BITS-1:2];

  // range check only exists when the space is narrower than a word
  generate
    if (ADDR_BITS < WORD_W) begin : g_range
      assign pcHiZero   = (pcQ[WORD_W-1:ADDR_BITS] == '0);
      assign dataHiZero = (aluResult[WORD_W-1:ADDR_BITS] == '0);
    end else begin : g_full
      assign pcHiZero   = 1'b1;
      assign dataHiZero = 1'b1;
    end
  endgenerate

  // next PC selection
  assign pcPlus4   = pcQ + 32'd4;
  assign branchTgt = pcPlus4 + (extOffset << 2);
  assign jumpTgt   = {pcPlus4[WORD_W-1:WORD_W-4], jumpField, 2'b00};

  always_comb begin
    if (jump)                  nextPc = jumpTgt;
    else if (branch && zeroFlag) nextPc = branchTgt;
    else                       nextPc = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcQ <= RESET_PC;
    else if (strb.advance) pcQ <= nextPc;
  end

  // memory: preload port wins over a step store
  always_ff @(posedge clk) begin
    if (preloadEn)         memArr[preloadIdx] <= preloadData;
    else if (strb.doWrite) memArr[dataIdx]    <= storeData;
  end

  assign instr    = memArr[fetchIdx];
  assign loadData = memArr[dataIdx];

  assign flags.pcOk      = (pcQ[1:0] == 2'b00) && pcHiZero;
  assign flags.instrZero = (instr == '0);
  assign flags.dataOk    = (aluResult[1:0] == 2'b00) && dataHiZero;

  // R12: a halted sequencer keeps its PC
  a_r12_pc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    haltedIn |=> $stable(pcQ));

  // R3: no advance strobe, no PC motion
  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(pcQ));

  // R3: every target the sequencer can produce is word aligned
  a_r3_pc_aligned: assert property (@(posedge clk) disable iff (!rstN)
    pcQ[1:0] == 2'b00);

  // R9 / R10: a store is only issued to an aligned in-range word, without a read
  a_r9_write_only_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |-> (flags.dataOk && memWrite && !memRead));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEn,
  input  logic       memRead,
  input  logic       memWrite,
  input  seqFlags_t  flags,
  output seqStrobe_t strb,
  output logic       haltQ
);
  logic active, accessReq, fault;

  assign active    = stepEn && !haltQ;
  assign accessReq = memRead || memWrite;
  assign fault     = !flags.pcOk || flags.instrZero ||
                     (memRead && memWrite) ||
                     (accessReq && !flags.dataOk);

  assign strb.advance = active && !fault;
  assign strb.doWrite = active && !fault && memWrite;
  assign strb.setHalt = active && fault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             haltQ <= 1'b0;
    else if (strb.setHalt) haltQ <= 1'b1;
  end

  // R12: halt is sticky
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  // R10: read and write together stop the sequencer
  a_r10_both_halt: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && memRead && memWrite) |=> haltQ);

  // R7: an all-zero fetch stops the sequencer
  a_r7_zero_word_halt: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && flags.instrZero) |=> haltQ);

  // R6: a bad fetch address stops the sequencer
  a_r6_fetch_halt: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !flags.pcOk) |=> haltQ);
endmodule

// File: rtl/insn_seq_unit.sv
module insn_seq_unit
  import seq_pkg::*;
#(
  parameter int ADDR_BITS = 13,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepEn,
  input  logic                 memRead,
  input  logic                 memWrite,
  input  logic                 branch,
  input  logic                 jump,
  input  logic                 zeroFlag,
  input  logic [31:0]          aluResult,
  input  logic [31:0]          storeData,
  input  logic [31:0]          extOffset,
  input  logic [25:0]          jumpField,
  input  logic                 preloadEn,
  input  logic [ADDR_BITS-3:0] preloadIdx,
  input  logic [31:0]          preloadData,
  output logic [31:0]          instr,
  output logic [31:0]          loadData,
  output logic                 halted
);
  seqStrobe_t strb;
  seqFlags_t  flags;
  logic       haltQ;

  seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stepEn   (stepEn),
    .memRead  (memRead),
    .memWrite (memWrite),
    .flags    (flags),
    .strb     (strb),
    .haltQ    (haltQ)
  );

  seq_dpath #(.ADDR_BITS(ADDR_BITS), .RESET_PC(RESET_PC)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .haltedIn    (haltQ),
    .memRead     (memRead),
    .memWrite    (memWrite),
    .branch      (branch),
    .jump        (jump),
    .zeroFlag    (zeroFlag),
    .aluResult   (aluResult),
    .storeData   (storeData),
    .extOffset   (extOffset),
    .jumpField   (jumpField),
    .preloadEn   (preloadEn),
    .preloadIdx  (preloadIdx),
    .preloadData (preloadData),
    .instr       (instr),
    .loadData    (loadData),
    .flags       (flags)
  );

  assign halted = haltQ;
endmodule

// File: tb/test_insn_seq_unit.sv
module test_insn_seq_unit;
  localparam int AB = 13;
  localparam logic [31:0] RPC = 32'h0000_1000;
  localparam int WIDX = AB - 2;
  localparam int DEPTH = 1 << WIDX;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn, memRead, memWrite, branch, jump, zeroFlag, preloadEn;
  logic [31:0] aluResult, storeData, extOffset, preloadData;
  logic [25:0] jumpField;
  logic [WIDX-1:0] preloadIdx;
  logic [31:0] instr, loadData;
  logic halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] expPc, v;

  insn_seq_unit #(.ADDR_BITS(AB), .RESET_PC(RPC)) i_insn_seq_unit (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .memRead(memRead),
    .memWrite(memWrite), .branch(branch), .jump(jump), .zeroFlag(zeroFlag),
    .aluResult(aluResult), .storeData(storeData), .extOffset(extOffset),
    .jumpField(jumpField), .preloadEn(preloadEn), .preloadIdx(preloadIdx),
    .preloadData(preloadData), .instr(instr), .loadData(loadData),
    .halted(halted)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 | i;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clearIn;
    stepEn = 0; memRead = 0; memWrite = 0; branch = 0; jump = 0; zeroFlag = 0;
    aluResult = 0; storeData = 0; extOffset = 0; jumpField = 0;
    preloadEn = 0; preloadIdx = 0; preloadData = 0;
  endtask

  task automatic doStep(input logic rd, input logic wr, input logic br, input logic jp,
                        input logic zf, input logic [31:0] alu, input logic [31:0] st,
                        input logic [31:0] off, input logic [25:0] jf);
    memRead = rd; memWrite = wr; branch = br; jump = jp; zeroFlag = zf;
    aluResult = alu; storeData = st; extOffset = off; jumpField = jf;
    stepEn = 1;
    @(negedge clk);
    clearIn();
  endtask

  task automatic preload(input int idx, input logic [31:0] d);
    preloadEn = 1; preloadIdx = idx[WIDX-1:0]; preloadData = d;
    @(negedge clk);
    preloadEn = 0;
  endtask

  task automatic peek(input logic [31:0] addr, output logic [31:0] r);
    aluResult = addr;
    #1;
    r = loadData;
    aluResult = 0;
  endtask

  task automatic doReset;
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    clearIn();
    @(negedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk("R1 halt in reset", {31'b0, halted}, 32'h0);
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) preload(i, pat(i));
    // R1
    chk("R1 halt after reset", {31'b0, halted}, 32'h0);
    chk("R1 fetch at reset PC", instr, pat(RPC >> 2));

    // R2 / R8: every word readable at its byte address
    for (int i = 0; i < DEPTH; i++) begin
      peek(i * 4, v);
      chk("R2 word map", v, pat(i));
    end

    // R3: sequential steps
    expPc = RPC;
    for (int k = 0; k < 8; k++) begin
      doStep(0, 0, 0, 0, 0, 0, 0, 0, 0);
      expPc += 4;
      chk("R3 pc+4", instr, pat(expPc >> 2));
    end
    repeat (3) @(negedge clk);
    chk("R3 hold without step", instr, pat(expPc >> 2));
    chk("R3 no halt while idle", {31'b0, halted}, 32'h0);

    // R9: store at valid address
    doStep(0, 1, 0, 0, 0, 32'h40, 32'h1234_5678, 0, 0);
    expPc += 4;
    peek(32'h40, v);
    chk("R9 store lands", v, 32'h1234_5678);
    chk("R9 pc after store", instr, pat(expPc >> 2));

    // R5: branches
    doStep(0, 0, 1, 0, 0, 0, 0, 32'd3, 0);
    expPc += 4;
    chk("R5 branch zero low", instr, pat(expPc >> 2));
    doStep(0, 0, 1, 0, 1, 0, 0, 32'd3, 0);
    expPc = expPc + 4 + 12;
    chk("R5 branch forward", instr, pat(expPc >> 2));
    doStep(0, 0, 1, 0, 1, 0, 0, 32'hFFFF_FFFE, 0);
    expPc = expPc + 4 - 8;
    chk("R5 branch backward", instr, pat(expPc >> 2));
    doStep(0, 0, 0, 0, 1, 0, 0, 32'd5, 0);
    expPc += 4;
    chk("R5 zero without branch", instr, pat(expPc >> 2));

    // R4: jumps, including priority over a taken branch
    doStep(0, 0, 0, 1, 0, 0, 0, 0, 26'h300);
    expPc = {expPc[31:28], 26'h300, 2'b00};
    chk("R4 jump", instr, pat(expPc >> 2));
    doStep(0, 0, 1, 1, 1, 0, 0, 32'd7, 26'h450);
    expPc = {expPc[31:28], 26'h450, 2'b00};
    chk("R4 jump beats branch", instr, pat(expPc >> 2));

    // R11: no access, misaligned address ignored
    doStep(0, 0, 0, 0, 0, 32'h3, 0, 0, 0);
    expPc += 4;
    chk("R11 no halt", {31'b0, halted}, 32'h0);
    chk("R11 pc advances", instr, pat(expPc >> 2));

    // R8: valid load step
    doStep(1, 0, 0, 0, 0, 32'h44, 0, 0, 0);
    expPc += 4;
    chk("R8 valid load no halt", {31'b0, halted}, 32'h0);

    // R10: read and write together
    doStep(1, 1, 0, 0, 0, 32'h80, 32'hDEAD_BEEF, 0, 0);
    chk("R10 halt", {31'b0, halted}, 32'h1);
    peek(32'h80, v);
    chk("R10 no write", v, pat(32'h20));
    chk("R10 pc frozen", instr, pat(expPc >> 2));

    // R12: sticky, frozen, writes blocked
    doStep(0, 1, 0, 0, 0, 32'h84, 32'h55, 0, 0);
    chk("R12 halt stays", {31'b0, halted}, 32'h1);
    peek(32'h84, v);
    chk("R12 store blocked", v, pat(32'h21));
    doStep(0, 0, 0, 1, 0, 0, 0, 0, 26'h10);
    chk("R12 jump blocked", instr, pat(expPc >> 2));
    doReset();
    chk("R12 reset clears halt", {31'b0, halted}, 32'h0);
    chk("R1 pc after reset", instr, pat(RPC >> 2));

    // R8: misaligned load
    doStep(1, 0, 0, 0, 0, 32'h42, 0, 0, 0);
    chk("R8 misaligned load halts", {31'b0, halted}, 32'h1);
    chk("R8 pc frozen", instr, pat(RPC >> 2));
    doReset();

    // R9: misaligned store
    doStep(0, 1, 0, 0, 0, 32'h62, 32'h77, 0, 0);
    chk("R9 misaligned store halts", {31'b0, halted}, 32'h1);
    peek(32'h60, v);
    chk("R9 misaligned store no write", v, pat(32'h18));
    doReset();

    // R8 / R9: out of range
    doStep(1, 0, 0, 0, 0, 32'h2000, 0, 0, 0);
    chk("R8 out-of-range load halts", {31'b0, halted}, 32'h1);
    doReset();
    doStep(0, 1, 0, 0, 0, 32'h2010, 32'h99, 0, 0);
    chk("R9 out-of-range store halts", {31'b0, halted}, 32'h1);
    peek(32'h10, v);
    chk("R9 out-of-range no alias write", v, pat(4));
    doReset();

    // R6: jump beyond memory, halt on the following fetch
    doStep(0, 0, 0, 1, 0, 0, 0, 0, 26'h900);
    chk("R6 jump itself fine", {31'b0, halted}, 32'h0);
    doStep(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 fetch out of range halts", {31'b0, halted}, 32'h1);
    doReset();

    // R7: zero word
    preload(32'h5DC, 32'h0);
    doStep(0, 0, 0, 1, 0, 0, 0, 0, 26'h5DC);
    chk("R7 reached zero word", instr, 32'h0);
    chk("R7 not yet halted", {31'b0, halted}, 32'h0);
    doStep(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 zero word halts", {31'b0, halted}, 32'h1);
    doReset();
    preload(32'h5DC, pat(32'h5DC));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule